// File: doc/BRIEF.md
# Glitch-Free Card Clock Divider and Parking Unit

This block derives the clock sent to a smart card from the host's input clock. A two-bit select chooses the input divided by 8, 4 or 2, or the input itself passed straight through. The divided clocks are built from registers on the input's rising edge. The pass-through path is the input clock ANDed with a gate that is updated on the falling edge. The output is the OR of the divided level and the gated input, so it cannot glitch when control changes.

A single state machine (`ck_state_e`) owns every change of output behaviour and has four states. CK_STOPPED holds the output low while the card is inactive. CK_PARKED holds the power-down park level. CK_DIVIDE produces a divided clock. CK_PASS forwards the input. Each decision is made at a rising edge of the input, and most wait for the end of the current output phase. Its transitions are:
- stop (any running state to CK_STOPPED on enable low);
- park (a running state to CK_PARKED on power-down);
- ratio-switch (CK_DIVIDE to CK_DIVIDE with a new ratio, at the end of a low phase);
- enter-pass (CK_DIVIDE to CK_PASS, at the end of a low phase);
- leave-pass (CK_PASS to CK_DIVIDE);
- resume (CK_PARKED or CK_STOPPED to CK_DIVIDE or CK_PASS);
- unpark-stop (CK_PARKED to CK_STOPPED);
- wake-park (CK_STOPPED to CK_PARKED).

Top module: `card_clk_sel`

## Requirements
- R1: With `div_sel` = 00, 01 or 10, the output is the input divided by 8, 4 or 2. It is high for 4, 2 or 1 input cycles and then low for the same count.
- R2: With `div_sel` = 11, the output is high exactly during the input's high phases, so its duty cycle follows the input. Power-down and enable handling are unaffected.
- R3: A new divided ratio takes effect only when a low phase of the old ratio has run its full length. The new ratio then starts with a full-length high phase, so no phase is ever shorter than its own ratio's half period. A select value that changes several times before that point is sampled only once, at that point.
- R4: Changing from a divided ratio to pass-through also waits for the end of a low phase. The input's pulses then start one input cycle later. Changing from pass-through to a divided ratio starts a full high phase at the next rising edge of the input.
- R5: Asserting `pd_req` lets the current phase finish. The output then holds high if `park_high` = 1, or low if `park_high` = 0, for as long as power-down lasts.
- R6: Releasing `pd_req` resumes the selected ratio, starting with a full phase at the parked level.
- R7: Dropping `card_en` lets the current phase finish and then holds the output low. From the parked state the output drops low at once. The output stays low while `card_en` is low, whatever `pd_req` is.
- R8: During reset and after it, the output is low until `card_en` is raised.
- R9: Raising `card_en` with `pd_req` low starts the selected divided ratio with a full low phase, or starts pass-through pulses one input cycle later.
- R10: In pass-through, power-down takes effect at the next rising edge of the input. Park high merges with the current input high phase, and park low lets the current input high phase end.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock; also clocks all control state |
| rst_n | input | 1 | Asynchronous active-low reset |
| card_en | input | 1 | Card active, from the activation sequencer |
| pd_req | input | 1 | Power-down request |
| park_high | input | 1 | Park level in power-down: 1 high, 0 low |
| div_sel | input | 2 | Ratio select: 00 /8, 01 /4, 10 /2, 11 pass-through |
| card_clk | output | 1 | Clock to the card |

## Verification
The assertions assume that `card_en`, `pd_req`, `park_high` and `div_sel` are synchronous to `clk_in` and settle well before its rising edge. They also assume that the pass-through gate sees every falling edge of the input between two rising edges. The bench keeps to this by changing every control input 7 ns after a falling edge, and by sampling the card clock 5 ns into each half cycle. A behavioural model predicts the level of every half cycle. Random sequences of select, power-down and enable changes, including changes in the middle of a phase and several select changes before a boundary, drive both the model and the design.

// File: rtl/card_clk_pkg.sv
package card_clk_pkg;
    typedef enum logic [1:0] {
        CK_STOPPED = 2'd0,
        CK_PARKED  = 2'd1,
        CK_DIVIDE  = 2'd2,
        CK_PASS    = 2'd3
    } ck_state_e;
endpackage

// File: rtl/ckdiv_ratio_ctl.sv
module ckdiv_ratio_ctl
    import card_clk_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic             clk_in,
    input  logic             rst_n,
    input  logic             card_en,
    input  logic             pd_req,
    input  logic             park_high,
    input  logic [SEL_W-1:0] div_sel,
    output ck_state_e        state_q,
    output logic             level_q
);
    localparam int CNT_W = SEL_W;
    localparam logic [SEL_W-1:0] PASS_CODE = '1;

    // Last count value of one phase for a divided code: 2^(SEL_W-code) cycles.
    function automatic logic [CNT_W-1:0] last_cnt(input logic [SEL_W-1:0] code);
        int span;
        if (code == PASS_CODE) begin
            return '0;
        end
        span = (1 << (SEL_W - int'(code))) - 1;
        return CNT_W'(span);
    endfunction

    ck_state_e        state_d;
    logic             level_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [SEL_W-1:0] cur_sel_q, cur_sel_d;

    logic      hold_req;
    logic      hold_lvl;
    ck_state_e hold_state;
    logic      phase_end;

    assign hold_req   = !card_en || pd_req;
    assign hold_lvl   = card_en && park_high;
    assign hold_state = card_en ? CK_PARKED : CK_STOPPED;
    assign phase_end  = (cnt_q == last_cnt(cur_sel_q));

    // Next-state and output-level decisions
    always_comb begin
        state_d   = state_q;
        level_d   = level_q;
        cnt_d     = cnt_q;
        cur_sel_d = cur_sel_q;
        unique case (state_q)
            CK_DIVIDE: begin
                if (phase_end) begin
                    cnt_d = '0;
                    if (hold_req) begin
                        state_d = hold_state;
                        level_d = hold_lvl;
                    end else if (!level_q && (div_sel != cur_sel_q)) begin
                        cur_sel_d = div_sel;
                        if (div_sel == PASS_CODE) begin
                            state_d = CK_PASS;
                            level_d = 1'b0;
                        end else begin
                            level_d = 1'b1;
                        end
                    end else begin
                        level_d = !level_q;
                    end
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            CK_PASS: begin
                cnt_d = '0;
                if (hold_req) begin
                    state_d = hold_state;
                    level_d = hold_lvl;
                end else if (div_sel != PASS_CODE) begin
                    cur_sel_d = div_sel;
                    state_d   = CK_DIVIDE;
                    level_d   = 1'b1;
                end
            end
            CK_PARKED: begin
                cnt_d = '0;
                if (!card_en) begin
                    state_d = CK_STOPPED;
                    level_d = 1'b0;
                end else if (!pd_req) begin
                    cur_sel_d = div_sel;
                    if (div_sel == PASS_CODE) begin
                        state_d = CK_PASS;
                        level_d = 1'b0;
                    end else begin
                        state_d = CK_DIVIDE;
                    end
                end
            end
            CK_STOPPED: begin
                cnt_d = '0;
                if (card_en) begin
                    if (pd_req) begin
                        state_d = CK_PARKED;
                        level_d = park_high;
                    end else begin
                        cur_sel_d = div_sel;
                        if (div_sel == PASS_CODE) begin
                            state_d = CK_PASS;
                            level_d = 1'b0;
                        end else begin
                            state_d = CK_DIVIDE;
                        end
                    end
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= CK_STOPPED;
            level_q   <= 1'b0;
            cnt_q     <= '0;
            cur_sel_q <= '0;
        end else begin
            state_q   <= state_d;
            level_q   <= level_d;
            cnt_q     <= cnt_d;
            cur_sel_q <= cur_sel_d;
        end
    end

    always_ff @(posedge clk_in) begin
        if (rst_n && state_q == CK_DIVIDE) begin
            AST_CNT_IN_PHASE: assert (cnt_q <= last_cnt(cur_sel_q)); // R1
        end
    end

    AST_DIV_NOT_PASS_CODE: assert property (@(posedge clk_in) disable iff (!rst_n)
        (state_q == CK_DIVIDE) |-> (cur_sel_q != PASS_CODE)); // R1

    AST_RATIO_AT_LOW: assert property (@(posedge clk_in) disable iff (!rst_n)
        (($past(state_q) == CK_DIVIDE) && (cur_sel_q != $past(cur_sel_q)))
        |-> !$past(level_q)); // R3

    AST_PARK_HOLD: assert property (@(posedge clk_in) disable iff (!rst_n)
        ((state_q == CK_PARKED) && ($past(state_q) == CK_PARKED)) |-> $stable(level_q)); // R5

    AST_STOP_LOW: assert property (@(posedge clk_in) disable iff (!rst_n)
        ((state_q == CK_STOPPED) && ($past(state_q) == CK_STOPPED)) |-> !level_q); // R7

    AST_PASS_NO_LEVEL: assert property (@(posedge clk_in) disable iff (!rst_n)
        ((state_q == CK_PASS) && ($past(state_q) == CK_PASS)) |-> !level_q); // R2
endmodule

// File: rtl/ckdiv_pass_gate.sv
module ckdiv_pass_gate (
    input  logic clk_in,
    input  logic rst_n,
    input  logic pass_active,
    input  logic level_q,
    output logic card_clk
);
    logic gate_q;

    // Gate updated while the input is low, so the AND never chops a high phase.
    always_ff @(negedge clk_in or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
        end else begin
            gate_q <= pass_active;
        end
    end

    assign card_clk = level_q | (clk_in & gate_q);

    AST_GATE_FOLLOWS: assert property (@(posedge clk_in) disable iff (!rst_n)
        gate_q == pass_active); // R2

    AST_GATE_LEVEL_EXCL: assert property (@(posedge clk_in) disable iff (!rst_n)
        (gate_q && $past(pass_active) && pass_active) |-> !level_q); // R4
endmodule

// File: rtl/card_clk_sel.sv
module card_clk_sel
    import card_clk_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic             clk_in,
    input  logic             rst_n,
    input  logic             card_en,
    input  logic             pd_req,
    input  logic             park_high,
    input  logic [SEL_W-1:0] div_sel,
    output logic             card_clk
);
    ck_state_e state_q;
    logic      level_q;
    logic      pass_active;

    ckdiv_ratio_ctl #(.SEL_W(SEL_W)) u_ctl (
        .clk_in    (clk_in),
        .rst_n     (rst_n),
        .card_en   (card_en),
        .pd_req    (pd_req),
        .park_high (park_high),
        .div_sel   (div_sel),
        .state_q   (state_q),
        .level_q   (level_q)
    );

    assign pass_active = (state_q == CK_PASS);

    ckdiv_pass_gate u_gate (
        .clk_in      (clk_in),
        .rst_n       (rst_n),
        .pass_active (pass_active),
        .level_q     (level_q),
        .card_clk    (card_clk)
    );

    AST_DISABLED_QUIET: assert property (@(posedge clk_in) disable iff (!rst_n)
        (!$past(card_en) && !card_en && (state_q != CK_DIVIDE) && (state_q != CK_PASS))
        |-> !level_q); // R7
endmodule

// File: tb/tb_card_clk_sel.sv
module tb_card_clk_sel;
    localparam int M_STOP = 0;
    localparam int M_PARK = 1;
    localparam int M_DIV  = 2;
    localparam int M_PASS = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       pd = 1'b0;
    logic       park = 1'b0;
    logic [1:0] sel = 2'b00;
    logic       card_clk;

    int    checks = 0;
    int    errors = 0;
    string tag = "R8";
    bit    done = 1'b0;

    always #10 clk = ~clk;

    card_clk_sel dut (
        .clk_in    (clk),
        .rst_n     (rst_n),
        .card_en   (en),
        .pd_req    (pd),
        .park_high (park),
        .div_sel   (sel),
        .card_clk  (card_clk)
    );

    // Behavioural reference: level per half cycle of the input.
    int m_mode = M_STOP;
    int m_lvl = 0;
    int m_elapsed = 0;
    int m_sel = 0;
    int m_prev_pass = 0;

    function automatic int half_of(int s);
        return 8 >> (s + 1);
    endfunction

    task automatic m_resume();
        m_sel = int'(sel);
        m_elapsed = 0;
        if (m_sel == 3) begin
            m_mode = M_PASS;
            m_lvl = 0;
        end else begin
            m_mode = M_DIV;
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = M_STOP; m_lvl = 0; m_elapsed = 0; m_sel = 0; m_prev_pass = 0;
        end else begin
            bit hold;
            int hl;
            hold = !en || pd;
            hl = (en && park) ? 1 : 0;
            m_prev_pass = (m_mode == M_PASS) ? 1 : 0;
            case (m_mode)
                M_DIV: begin
                    m_elapsed++;
                    if (m_elapsed == half_of(m_sel)) begin
                        m_elapsed = 0;
                        if (hold) begin
                            m_mode = en ? M_PARK : M_STOP;
                            m_lvl = hl;
                        end else if (m_lvl == 0 && int'(sel) != m_sel) begin
                            m_sel = int'(sel);
                            if (m_sel == 3) begin
                                m_mode = M_PASS;
                                m_lvl = 0;
                            end else begin
                                m_lvl = 1;
                            end
                        end else begin
                            m_lvl = 1 - m_lvl;
                        end
                    end
                end
                M_PASS: begin
                    m_elapsed = 0;
                    if (hold) begin
                        m_mode = en ? M_PARK : M_STOP;
                        m_lvl = hl;
                    end else if (sel != 2'b11) begin
                        m_sel = int'(sel);
                        m_mode = M_DIV;
                        m_lvl = 1;
                    end
                end
                M_PARK: begin
                    if (!en) begin
                        m_mode = M_STOP;
                        m_lvl = 0;
                    end else if (!pd) begin
                        m_resume();
                    end
                end
                default: begin
                    if (en) begin
                        if (pd) begin
                            m_mode = M_PARK;
                            m_lvl = park ? 1 : 0;
                        end else begin
                            m_resume();
                        end
                    end
                end
            endcase
        end
    end

    task automatic check_level(input int exp, input string phase);
        checks++;
        if (int'(card_clk) != exp) begin
            errors++;
            $display("FAIL %s card_clk in %s half at %0t: got %0d expected %0d",
                     tag, phase, $time, card_clk, exp);
        end
    endtask

    always @(posedge clk) begin
        #5;
        if (!done) check_level(m_lvl | m_prev_pass, "high");
    end

    always @(negedge clk) begin
        #5;
        if (!done) check_level(m_lvl, "low");
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #7;
    endtask

    initial begin
        #4_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog expired: got hang expected completion");
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tag = "R8";
        step(4);
        rst_n = 1'b1;
        step(4);
        // Enable start with full low phase, then steady /8
        tag = "R9"; en = 1'b1; sel = 2'b00; step(12);
        tag = "R1"; step(30);
        // Ratio changes, including mid-phase and repeated changes
        tag = "R3"; sel = 2'b01; step(24);
        sel = 2'b10; step(16);
        sel = 2'b00; step(30);
        sel = 2'b01; step(1);
        sel = 2'b10; step(3);
        sel = 2'b00; step(30);
        tag = "R1"; sel = 2'b10; step(16);
        tag = "R2"; sel = 2'b11; step(20);
        tag = "R4"; sel = 2'b01; step(20);
        sel = 2'b11; step(12);
        sel = 2'b00; step(30);
        // Power-down from divided mode, both park levels
        tag = "R5"; park = 1'b1; pd = 1'b1; step(20);
        tag = "R6"; pd = 1'b0; step(30);
        tag = "R5"; park = 1'b0; pd = 1'b1; step(20);
        tag = "R6"; pd = 1'b0; sel = 2'b10; step(20);
        // Power-down from pass-through
        tag = "R10"; sel = 2'b11; step(10);
        park = 1'b1; pd = 1'b1; step(10);
        pd = 1'b0; step(10);
        park = 1'b0; pd = 1'b1; step(10);
        pd = 1'b0; step(10);
        // Enable removal
        tag = "R7"; sel = 2'b00; step(20);
        en = 1'b0; step(20);
        pd = 1'b1; park = 1'b1; step(10);
        en = 1'b1; step(10);
        en = 1'b0; step(10);
        pd = 1'b0; en = 1'b1; sel = 2'b11; step(10);
        en = 1'b0; step(10);
        tag = "R9"; en = 1'b1; sel = 2'b01; step(20);
        // Mixed random control traffic
        tag = "R3";
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 5) == 0) sel = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 30) == 0) pd = ~pd;
            if ($urandom_range(0, 20) == 0) park = ~park;
            if ($urandom_range(0, 60) == 0) en = ~en;
            step(1);
        end
        step(2);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule